// File: doc/BRIEF.md
# Scan-Line Pixel Streamer with Colour Lookup

This block produces the pixel stream for one scan line without help from the processor, which can meanwhile build the next line. A single command gives a start word address, a final word address, a pixel duration in system clocks and an output format. The streamer then walks the processor's local register RAM. It reads a pair of words for each step: a colour word and a pixel word holding four 8-bit indices. Each read takes the RAM port, and so stalls the processor, for one clock. The streamer prefetches the next pair while the current one is being shown, so the output never has a gap.

Each index, offset by the low byte of the colour word, selects an entry in a loadable 256-entry colour table of 16-bit words. In composite format the top six bits of the table word are a chroma phase. A free-running 6-bit phase counter is added to them, and the counter can be cleared so that several streamers line up. In VGA format the table word goes out unchanged. Until the last pixel of the final pair has been shown, the block holds off any further command.

Top module: `svs_streamer`

## Requirements
- R1: `cmd_ready` is high exactly while `busy` is low. A command is taken at a clock edge where `cmd_valid` and `cmd_ready` are both high, and `busy` is high in the following cycle.
- R2: A command presented while `busy` is high is not taken. It stays pending and is taken at the first edge after `busy` has fallen.
- R3: Pairs start at `cmd_begin` and advance by 2 up to and including `cmd_end`. For each pair, `ram_req` is high for one cycle with the colour address, then for the next cycle with that address plus 1. A run has exactly 2 request cycles per pair, and `ram_req` is never high while idle.
- R4: `pix_valid` first rises 4 clocks after the accepting edge and stays high, with no gap, for 4 × pairs × scale cycles.
- R5: Each pixel is held for `cmd_scale` cycles (scale ≥ 1). The bytes of the pixel word are shown least significant byte first.
- R6: The table index is the pixel byte plus bits [7:0] of the colour word, modulo 256.
- R7: Composite format (`cmd_mode` = 0): `pix_out[15:10]` = table[15:10] + phase (mod 64), and `pix_out[9:0]` = table[9:0].
- R8: VGA format (`cmd_mode` = 1): `pix_out` equals the table word, laid out as red [15:11], green [10:6], blue [5:2], horizontal sync [1], vertical sync [0].
- R9: The phase counter is 6 bits wide. It advances by 1 on every cycle that `pix_valid` is high and wraps at 64. `phase_clr` zeroes it, and the new value shows in the next cycle.
- R10: Each cycle with `clut_we` high writes one 16-bit word into the table at `clut_waddr`. A pixel using that entry shows the new word from the next cycle on, even in the middle of a run.
- R11: `busy` falls at the edge that ends the last pixel cycle of the final pair. While `busy` is low, `pix_valid` is 0 and `pix_out` is 0.
- R12: After reset, `busy`, `ram_req` and `pix_valid` are low and the phase counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start command present |
| cmd_ready | output | 1 | Command can be taken (block idle) |
| cmd_begin | input | AW | Word address of the first pair's colour word |
| cmd_end | input | AW | Word address of the last pair's colour word |
| cmd_scale | input | SW | System clocks per pixel, at least 1 |
| cmd_mode | input | 1 | 0 composite, 1 VGA |
| busy | output | 1 | Run in progress |
| ram_req | output | 1 | RAM port request; stalls the processor this cycle |
| ram_addr | output | AW | RAM word address |
| ram_rdata | input | 32 | RAM data, valid the cycle after a request |
| clut_we | input | 1 | Colour table write strobe |
| clut_waddr | input | 8 | Colour table entry |
| clut_wdata | input | 16 | Colour table word |
| phase_clr | input | 1 | Zero the chroma phase counter |
| pix_valid | output | 1 | Pixel output valid |
| pix_out | output | 16 | Formatted pixel word |

## Verification
The properties assume that the RAM returns data exactly one cycle after a request, that `cmd_scale` is at least 1, and that `cmd_end` is not below `cmd_begin`, with an even difference. They also assume that the command fields stay steady while `cmd_valid` waits for acceptance. The stimulus keeps to these: every command uses an even address span inside the bench RAM and a non-zero scale, the bench RAM is a one-cycle registered read, and the RAM contents are left unchanged during a run. Commands that arrive while busy, phase clears in the middle of a line, and table writes in the middle of a line are applied only through the block's ports.

// File: rtl/svs_pkg.sv
package svs_pkg;

    localparam int WORD_W       = 32;
    localparam int PIX_W        = 8;
    localparam int PIX_PER_WORD = WORD_W / PIX_W;
    localparam int PCW          = $clog2(PIX_PER_WORD);
    localparam int CLUT_W       = 16;
    localparam int CLUT_DEPTH   = 1 << PIX_W;
    localparam int PH_W         = 6;

    typedef enum logic [2:0] {
        F_IDLE,
        F_COL,
        F_PIX,
        F_CAP,
        F_FULL
    } fetch_st_t;

    typedef enum logic {
        FMT_COMP = 1'b0,
        FMT_VGA  = 1'b1
    } vid_fmt_t;

    typedef struct packed {
        logic [WORD_W-1:0] colour;
        logic [WORD_W-1:0] pixels;
        logic              last;
    } pair_t;

    function automatic logic [CLUT_W-1:0] fmt_word(
        input vid_fmt_t          fmt,
        input logic [CLUT_W-1:0] entry,
        input logic [PH_W-1:0]   phase
    );
        logic [PH_W-1:0] ph_sum;
        ph_sum = entry[CLUT_W-1 -: PH_W] + phase;
        if (fmt == FMT_VGA) return entry;
        return {ph_sum, entry[CLUT_W-PH_W-1:0]};
    endfunction

endpackage

// File: rtl/svs_fetch.sv
module svs_fetch
    import svs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     first_ptr,
    input  logic [AW-1:0]     last_ptr,
    input  logic [WORD_W-1:0] rdata,
    input  logic              take,
    output logic              req,
    output logic [AW-1:0]     addr,
    output logic              full,
    output pair_t             pair
);

    fetch_st_t   st;
    logic [AW-1:0] ptr;
    logic [AW-1:0] stop_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= F_IDLE;
            ptr      <= '0;
            stop_ptr <= '0;
            pair     <= '0;
        end else begin
            case (st)
                F_IDLE: if (start) begin
                    ptr      <= first_ptr;
                    stop_ptr <= last_ptr;
                    st       <= F_COL;
                end
                F_COL: st <= F_PIX;
                F_PIX: begin
                    pair.colour <= rdata;
                    st          <= F_CAP;
                end
                F_CAP: begin
                    pair.pixels <= rdata;
                    pair.last   <= (ptr == stop_ptr);
                    ptr         <= ptr + AW'(2);
                    st          <= F_FULL;
                end
                F_FULL: if (take) st <= pair.last ? F_IDLE : F_COL;
                default: st <= F_IDLE;
            endcase
        end
    end

    assign req  = (st == F_COL) || (st == F_PIX);
    assign addr = (st == F_PIX) ? ptr + AW'(1) : ptr;
    assign full = (st == F_FULL);

endmodule

// File: rtl/svs_shift.sv
module svs_shift
    import svs_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW-1:0]    scale,
    input  logic             full,
    input  pair_t            pair,
    output logic             take,
    output logic             active,
    output logic             done,
    output logic [PIX_W-1:0] index
);

    logic [WORD_W-1:0] word;
    logic [PIX_W-1:0]  offset;
    logic [PCW-1:0]    pix_cnt;
    logic [SW-1:0]     rep_cnt;
    logic              last_q;
    logic              rep_end;
    logic              pair_end;

    assign rep_end  = (rep_cnt == scale - SW'(1));
    assign pair_end = active && rep_end && (pix_cnt == PCW'(PIX_PER_WORD - 1));
    assign take     = full && (!active || pair_end);
    assign done     = pair_end && last_q;
    assign index    = word[PIX_W-1:0] + offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            word    <= '0;
            offset  <= '0;
            pix_cnt <= '0;
            rep_cnt <= '0;
            last_q  <= 1'b0;
        end else if (take) begin
            active  <= 1'b1;
            word    <= pair.pixels;
            offset  <= pair.colour[PIX_W-1:0];
            last_q  <= pair.last;
            pix_cnt <= '0;
            rep_cnt <= '0;
        end else if (active) begin
            if (rep_end) begin
                rep_cnt <= '0;
                if (pix_cnt == PCW'(PIX_PER_WORD - 1)) begin
                    active <= 1'b0;
                end else begin
                    pix_cnt <= pix_cnt + PCW'(1);
                    word    <= word >> PIX_W;
                end
            end else begin
                rep_cnt <= rep_cnt + SW'(1);
            end
        end
    end

endmodule

// File: rtl/svs_clut.sv
module svs_clut
    import svs_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [PIX_W-1:0]  waddr,
    input  logic [CLUT_W-1:0] wdata,
    input  logic [PIX_W-1:0]  raddr,
    output logic [CLUT_W-1:0] rdata
);

    logic [CLUT_W-1:0] mem [CLUT_DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/svs_streamer.sv
module svs_streamer
    import svs_pkg::*;
#(
    parameter int AW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_begin,
    input  logic [AW-1:0] cmd_end,
    input  logic [SW-1:0] cmd_scale,
    input  logic          cmd_mode,
    output logic          busy,
    output logic          ram_req,
    output logic [AW-1:0] ram_addr,
    input  logic [31:0]   ram_rdata,
    input  logic          clut_we,
    input  logic [7:0]    clut_waddr,
    input  logic [15:0]   clut_wdata,
    input  logic          phase_clr,
    output logic          pix_valid,
    output logic [15:0]   pix_out
);

    logic              accept;
    logic [SW-1:0]     scale_q;
    vid_fmt_t          fmt_q;
    logic [PH_W-1:0]   phase;
    logic              buf_full;
    pair_t             buf_pair;
    logic              take;
    logic              active;
    logic              done;
    logic [PIX_W-1:0]  index;
    logic [CLUT_W-1:0] entry;

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            scale_q <= SW'(1);
            fmt_q   <= FMT_COMP;
        end else if (accept) begin
            busy    <= 1'b1;
            scale_q <= cmd_scale;
            fmt_q   <= vid_fmt_t'(cmd_mode);
        end else if (done) begin
            busy    <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || phase_clr) phase <= '0;
        else if (active)      phase <= phase + PH_W'(1);
    end

    svs_fetch #(.AW(AW)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .first_ptr (cmd_begin),
        .last_ptr  (cmd_end),
        .rdata     (ram_rdata),
        .take      (take),
        .req       (ram_req),
        .addr      (ram_addr),
        .full      (buf_full),
        .pair      (buf_pair)
    );

    svs_shift #(.SW(SW)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .scale  (scale_q),
        .full   (buf_full),
        .pair   (buf_pair),
        .take   (take),
        .active (active),
        .done   (done),
        .index  (index)
    );

    svs_clut u_clut (
        .clk   (clk),
        .we    (clut_we),
        .waddr (clut_waddr),
        .wdata (clut_wdata),
        .raddr (index),
        .rdata (entry)
    );

    assign pix_valid = active;
    assign pix_out   = active ? fmt_word(fmt_q, entry, phase) : '0;

endmodule

// File: rtl/svs_checker.sv
module svs_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          busy,
    input logic          ram_req,
    input logic [AW-1:0] ram_addr,
    input logic          pix_valid,
    input logic [15:0]   pix_out
);

    AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        ram_req |-> busy); // R3

    AST_PIX_WORD_NEXT: assert property (@(posedge clk) disable iff (rst)
        (ram_req && !$past(ram_req)) |=> (ram_req && ram_addr == AW'($past(ram_addr) + AW'(1)))); // R3

    AST_STALL_MAX_TWO: assert property (@(posedge clk) disable iff (rst)
        (ram_req && $past(ram_req)) |=> !ram_req); // R3

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!pix_valid && pix_out == 16'h0)); // R11

    AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid)); // R1

    AST_NO_EARLY_PIX: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !pix_valid); // R4

endmodule

bind svs_streamer svs_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .ram_req   (ram_req),
    .ram_addr  (ram_addr),
    .pix_valid (pix_valid),
    .pix_out   (pix_out)
);

// File: tb/svs_streamer_tb.sv
module svs_streamer_tb;

    localparam int AW = 8;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_begin = '0;
    logic [AW-1:0] cmd_end = '0;
    logic [SW-1:0] cmd_scale = SW'(1);
    logic          cmd_mode = 1'b0;
    logic          busy;
    logic          ram_req;
    logic [AW-1:0] ram_addr;
    logic [31:0]   ram_rdata = '0;
    logic          clut_we = 1'b0;
    logic [7:0]    clut_waddr = '0;
    logic [15:0]   clut_wdata = '0;
    logic          phase_clr = 1'b0;
    logic          pix_valid;
    logic [15:0]   pix_out;

    always #10 clk = ~clk;

    svs_streamer #(.AW(AW), .SW(SW)) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_begin(cmd_begin), .cmd_end(cmd_end), .cmd_scale(cmd_scale),
        .cmd_mode(cmd_mode), .busy(busy), .ram_req(ram_req), .ram_addr(ram_addr),
        .ram_rdata(ram_rdata), .clut_we(clut_we), .clut_waddr(clut_waddr),
        .clut_wdata(clut_wdata), .phase_clr(phase_clr), .pix_valid(pix_valid),
        .pix_out(pix_out)
    );

    // bench RAM: one-cycle registered read
    logic [31:0] mem [64];
    always @(posedge clk) if (ram_req) ram_rdata <= mem[ram_addr[5:0]];

    int    vectors = 0;
    int    fails = 0;
    int    req_cnt = 0;
    int    cyc = 0;
    string tag = "R12";

    // reference model state
    int    m_busy = 0, m_active = 0, m_wait = 0, m_rep = 0, m_scale = 1, m_mode = 0, m_ph = 0;
    int    m_q[$];
    int    m_aq[$];
    int    m_clut [256];

    function automatic int expect_word();
        int e, ph;
        e = m_clut[m_q[0]];
        if (m_mode == 1) return e;
        ph = ((e >> 10) + m_ph) % 64;
        return (ph << 10) | (e & 16'h03FF);
    endfunction

    always @(posedge clk) begin
        int pre_busy, pre_active;
        pre_busy = m_busy;
        pre_active = m_active;
        if (rst) begin
            m_busy = 0; m_active = 0; m_wait = 0; m_rep = 0; m_ph = 0;
            m_q.delete(); m_aq.delete();
        end else begin
            if (clut_we) m_clut[clut_waddr] = clut_wdata;
            if (phase_clr) m_ph = 0;
            else if (pre_active != 0) m_ph = (m_ph + 1) % 64;
            if (pre_active != 0) begin
                m_rep++;
                if (m_rep == m_scale) begin
                    m_rep = 0;
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) begin
                        m_active = 0;
                        m_busy = 0;
                    end
                end
            end else if (pre_busy != 0) begin
                m_wait--;
                if (m_wait == 0) begin
                    m_active = 1;
                    m_rep = 0;
                end
            end
            if (cmd_valid && pre_busy == 0) begin
                m_busy = 1;
                m_wait = 4;
                m_scale = int'(cmd_scale);
                m_mode = int'(cmd_mode);
                for (int a = int'(cmd_begin); a <= int'(cmd_end); a += 2) begin
                    for (int k = 0; k < 4; k++)
                        m_q.push_back(((mem[a+1] >> (8*k)) + mem[a]) & 32'hFF);
                    m_aq.push_back(a);
                    m_aq.push_back(a + 1);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int got, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            int ew;
            ew = (m_active != 0) ? expect_word() : 0;
            chk(pix_valid == (m_active != 0), {tag, " R4 pix_valid"}, pix_valid, m_active);
            chk(pix_out == ew[15:0], {tag, " pix_out"}, pix_out, ew);
            chk(busy == (m_busy != 0), "R11 busy", busy, m_busy);
            chk(cmd_ready == (m_busy == 0), "R1 cmd_ready", cmd_ready, m_busy == 0);
            if (ram_req) begin
                req_cnt++;
                if (m_aq.size() == 0) chk(1'b0, "R3 unexpected ram_req", ram_addr, -1);
                else begin
                    chk(int'(ram_addr) == m_aq[0], "R3 ram_addr", ram_addr, m_aq[0]);
                    void'(m_aq.pop_front());
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic run(input int b, input int e, input int s, input int md,
                       input int clr_at, input int wr_at);
        int req0, n;
        @(negedge clk);
        cmd_begin = AW'(b); cmd_end = AW'(e); cmd_scale = SW'(s); cmd_mode = md[0];
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        req0 = req_cnt;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R1 busy after accept", busy, 1);
        n = 0;
        while (busy) begin
            phase_clr = (n == clr_at);
            clut_we = (n == wr_at) && (m_q.size() > 0) && (m_active != 0);
            if (clut_we) begin
                clut_waddr = m_q[0][7:0];
                clut_wdata = 16'hA5C3;
            end
            @(negedge clk);
            n++;
        end
        phase_clr = 1'b0;
        clut_we = 1'b0;
        chk(req_cnt - req0 == (e - b + 2), "R3 stall cycles per run", req_cnt - req0, e - b + 2);
        chk(m_aq.size() == 0, "R3 all pair words fetched", m_aq.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'(i) * 32'h01030507 + 32'h11223344;
        mem[20] = 32'h000000F0;
        mem[21] = 32'h30201510;
        for (int i = 0; i < 256; i++) m_clut[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R12";
        @(negedge clk);
        chk(!busy && !ram_req && !pix_valid, "R12 idle after reset", busy, 0);
        repeat (2) @(negedge clk);

        tag = "R10";
        for (int i = 0; i < 256; i++) begin
            clut_we = 1'b1; clut_waddr = 8'(i); clut_wdata = 16'(i * 40503 + 4660);
            @(negedge clk);
        end
        clut_we = 1'b0;

        tag = "R7";  run(0, 4, 1, 0, -1, -1);
        tag = "R8";  run(10, 12, 3, 1, -1, -1);
        tag = "R6";  run(20, 20, 1, 0, -1, -1);
        tag = "R5";  run(30, 30, 5, 1, -1, -1);
        tag = "R9";  run(40, 44, 2, 0, 9, -1);
        tag = "R10"; run(50, 50, 8, 1, -1, 12);
        tag = "R4";  run(0, 14, 1, 0, -1, -1);

        // R2: second command offered while busy is held off
        tag = "R2";
        @(negedge clk);
        cmd_begin = 8'd2; cmd_end = 8'd6; cmd_scale = 8'd2; cmd_mode = 1'b0; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_begin = 8'd24; cmd_end = 8'd26; cmd_scale = 8'd1; cmd_mode = 1'b1;
        chk(cmd_ready == 1'b0, "R2 ready low while busy", cmd_ready, 0);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R2 held command taken after busy fell", busy, 1);
        while (busy) @(negedge clk);
        chk(m_aq.size() == 0, "R3 held run fetched", m_aq.size(), 0);
        repeat (3) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule